// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block sits beside one channel of a 16550-style serial controller and turns its five interrupt sources into the identification byte the host reads and a single interrupt request line. Each cycle it masks the pending sources with the interrupt-enable bits and picks the most urgent one. It then presents that source's code together with the FIFO-enabled indication and an active-low "nothing pending" bit.

The sources arrive as one-cycle event strobes, except for the FIFO trigger-level condition, which is a level. The host's register accesses also arrive as one-cycle strobes: line status read, receive buffer read, identification read, transmit holding write and modem status read. Each source is held until its own access clears it. The receiver, transmitter, FIFOs and modem-line logic that raise these conditions are outside this block.

Top module: `uart_irq_prioritizer`

## Requirements
- R1: After reset, with no source pending, the identification byte reads 0x01 (bit 0 = 1 means nothing pending) and `irq` is 0.
- R2: Identification bits 7:6 read 11 while `fifo_en` is 1 and 00 otherwise; bits 5:4 always read 0.
- R3: A `ls_err` strobe makes the line status source pending with bits 3:0 = 0110; it stays pending until a `lsr_rd` strobe.
- R4: With FIFOs off, a `rx_char` strobe makes the received data source pending with bits 3:0 = 0100 until a `rbr_rd` strobe.
- R5: With FIFOs on, the received data source (code 0100) follows the `rx_trig` level, and `rbr_rd` has no effect on it.
- R6: A `rx_tmo` strobe makes the character timeout source pending with bits 3:0 = 1100 only while `fifo_en` is 1; `rbr_rd` clears it, and it never appears while FIFOs are off. When both are pending, received data is reported before timeout.
- R7: `ier_rx` gates both the received data and the timeout sources; `ier_ls`, `ier_tx` and `ier_ms` gate their own sources.
- R8: A `thr_empty` strobe makes the transmitter source pending with bits 3:0 = 0010. It is cleared by `thr_wr`, or by `iir_rd` only while it is the reported source.
- R9: A `modem_chg` strobe makes the modem source pending with bits 3:0 = 0000 until a `msr_rd` strobe.
- R10: The fixed priority is line status, then received data or timeout, then transmitter, then modem status.
- R11: `irq` is 1 exactly when an enabled source is pending and `out2` is 1.
- R12: A set strobe and a clear strobe for the same source in one cycle leave the source pending.
- R13: A source that is pending while disabled stays pending and is reported as soon as it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode active |
| ier_rx | input | 1 | Enable for received data and timeout |
| ier_tx | input | 1 | Enable for transmitter empty |
| ier_ls | input | 1 | Enable for line status |
| ier_ms | input | 1 | Enable for modem status |
| out2 | input | 1 | Modem control output gate for the request line |
| ls_err | input | 1 | Overrun, parity, framing or break event |
| rx_char | input | 1 | Character received (non-FIFO mode) |
| rx_trig | input | 1 | Receive FIFO at or above trigger (level) |
| rx_tmo | input | 1 | Character timeout event |
| thr_empty | input | 1 | Transmit holding register became empty |
| modem_chg | input | 1 | Modem input change event |
| lsr_rd | input | 1 | Line status register read |
| rbr_rd | input | 1 | Receive buffer or FIFO read |
| iir_rd | input | 1 | Identification register read |
| thr_wr | input | 1 | Transmit holding register write |
| msr_rd | input | 1 | Modem status register read |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the fixed bits of the identification byte, that the request line never rises without `out2` or while bit 0 shows nothing pending, and that timeout is never shown outside FIFO mode. They also check that each clearing access removes its source's code on the next cycle when no new event arrives. The ordering of several pending sources as each is cleared in turn, the identification read that must leave a lower transmitter source untouched, and a masked source that appears on being enabled can only be shown by the bench's scenarios.

// File: rtl/uart_irq_prioritizer.sv
module uart_irq_prioritizer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       ier_rx,
  input  logic       ier_tx,
  input  logic       ier_ls,
  input  logic       ier_ms,
  input  logic       out2,
  input  logic       ls_err,
  input  logic       rx_char,
  input  logic       rx_trig,
  input  logic       rx_tmo,
  input  logic       thr_empty,
  input  logic       modem_chg,
  input  logic       lsr_rd,
  input  logic       rbr_rd,
  input  logic       iir_rd,
  input  logic       thr_wr,
  input  logic       msr_rd,
  output logic [7:0] iir,
  output logic       irq
);

  localparam logic [2:0] CodeLine  = 3'b011;
  localparam logic [2:0] CodeRx    = 3'b010;
  localparam logic [2:0] CodeTmo   = 3'b110;
  localparam logic [2:0] CodeTx    = 3'b001;
  localparam logic [2:0] CodeModem = 3'b000;

  logic ls_q, rxc_q, tmo_q, tx_q, ms_q;
  logic act_ls, act_rx, act_tmo, act_tx, act_ms;
  logic pend, tx_shown;
  logic [2:0] code;

  assign act_ls  = ier_ls & ls_q;
  assign act_rx  = ier_rx & (fifo_en ? rx_trig : rxc_q);
  assign act_tmo = ier_rx & fifo_en & tmo_q;
  assign act_tx  = ier_tx & tx_q;
  assign act_ms  = ier_ms & ms_q;
  assign pend    = act_ls | act_rx | act_tmo | act_tx | act_ms;

  always_comb begin
    if (act_ls)       code = CodeLine;
    else if (act_rx)  code = CodeRx;
    else if (act_tmo) code = CodeTmo;
    else if (act_tx)  code = CodeTx;
    else              code = CodeModem;
  end

  assign tx_shown = act_tx & ~act_ls & ~act_rx & ~act_tmo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_q  <= 1'b0;
      rxc_q <= 1'b0;
      tmo_q <= 1'b0;
      tx_q  <= 1'b0;
      ms_q  <= 1'b0;
    end else begin
      ls_q  <= ls_err | (ls_q & ~lsr_rd);
      rxc_q <= ~fifo_en & (rx_char | (rxc_q & ~rbr_rd));
      tmo_q <= fifo_en & (rx_tmo | (tmo_q & ~rbr_rd));
      tx_q  <= thr_empty | (tx_q & ~thr_wr & ~(iir_rd & tx_shown));
      ms_q  <= modem_chg | (ms_q & ~msr_rd);
    end
  end

  assign iir = {fifo_en, fifo_en, 2'b00, code, ~pend};
  assign irq = pend & out2;

endmodule

// File: rtl/uart_irq_prioritizer_chk.sv
module uart_irq_prioritizer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       out2,
  input logic       ls_err,
  input logic       thr_empty,
  input logic       modem_chg,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic       msr_rd,
  input logic [7:0] iir,
  input logic       irq
);

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    iir[5:4] == 2'b00 && iir[7:6] == {fifo_en, fifo_en}); // R2

  AST_IRQ_NEEDS_OUT2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out2 && !iir[0]); // R11

  AST_NO_TMO_NOFIFO: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> iir[3:0] != 4'b1100); // R6

  AST_LS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !ls_err |=> iir[3:0] != 4'b0110); // R3

  AST_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && !thr_empty |=> iir[3:0] != 4'b0010); // R8

  AST_MS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    msr_rd && !modem_chg |=> iir[3:0] != 4'b0000); // R9

endmodule

bind uart_irq_prioritizer uart_irq_prioritizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .out2(out2),
  .ls_err(ls_err), .thr_empty(thr_empty), .modem_chg(modem_chg),
  .lsr_rd(lsr_rd), .thr_wr(thr_wr), .msr_rd(msr_rd),
  .iir(iir), .irq(irq)
);

// File: tb/test_uart_irq_prioritizer.sv
module test_uart_irq_prioritizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, ier_rx = 1, ier_tx = 1, ier_ls = 1, ier_ms = 1, out2 = 1;
  logic ls_err = 0, rx_char = 0, rx_trig = 0, rx_tmo = 0, thr_empty = 0, modem_chg = 0;
  logic lsr_rd = 0, rbr_rd = 0, iir_rd = 0, thr_wr = 0, msr_rd = 0;
  logic [7:0] iir;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_prioritizer i_uart_irq_prioritizer (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier_rx(ier_rx), .ier_tx(ier_tx),
    .ier_ls(ier_ls), .ier_ms(ier_ms), .out2(out2), .ls_err(ls_err), .rx_char(rx_char),
    .rx_trig(rx_trig), .rx_tmo(rx_tmo), .thr_empty(thr_empty), .modem_chg(modem_chg),
    .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .iir_rd(iir_rd), .thr_wr(thr_wr), .msr_rd(msr_rd),
    .iir(iir), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one clock: strobes set before the call are seen at the edge, then dropped
  task automatic step();
    @(negedge clk);
    ls_err = 0; rx_char = 0; rx_tmo = 0; thr_empty = 0; modem_chg = 0;
    lsr_rd = 0; rbr_rd = 0; iir_rd = 0; thr_wr = 0; msr_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_fifo_bits();
    fifo_en = 1; #1;
    chk("R2 fifo on", iir, 8'hC1);
    fifo_en = 0; #1;
    chk("R2 fifo off", iir, 8'h01);
    step();
  endtask

  task automatic t_line();
    ls_err = 1; step();
    chk("R3 set", iir, 8'h06);
    chk("R11 irq", {7'd0, irq}, 8'h01);
    step();
    chk("R3 held", iir, 8'h06);
    lsr_rd = 1; step();
    chk("R3 clear", iir, 8'h01);
  endtask

  task automatic t_rx_nofifo();
    rx_char = 1; step();
    chk("R4 set", iir, 8'h04);
    rbr_rd = 1; step();
    chk("R4 clear", iir, 8'h01);
  endtask

  task automatic t_rx_fifo();
    fifo_en = 1; rx_trig = 1; step();
    chk("R5 level", iir, 8'hC4);
    rbr_rd = 1; step();
    chk("R5 read ignored", iir, 8'hC4);
    rx_trig = 0; #1;
    chk("R5 drop", iir, 8'hC1);
    step();
  endtask

  task automatic t_timeout();
    rx_tmo = 1; step();
    chk("R6 set", iir, 8'hCC);
    rbr_rd = 1; step();
    chk("R6 clear", iir, 8'hC1);
    rx_trig = 1; rx_tmo = 1; step();
    chk("R6 rx first", iir, 8'hC4);
    rx_trig = 0; #1;
    chk("R6 tmo next", iir, 8'hCC);
    rbr_rd = 1; step();
    fifo_en = 0; rx_tmo = 1; step();
    chk("R6 ignored nofifo", iir, 8'h01);
    fifo_en = 1; step();
    chk("R6 not latched", iir, 8'hC1);
    fifo_en = 0; step();
  endtask

  task automatic t_enable();
    ier_rx = 0; rx_char = 1; step();
    chk("R7 masked", iir, 8'h01);
    chk("R7 irq", {7'd0, irq}, 8'h00);
    ier_rx = 1; #1;
    chk("R13 shown", iir, 8'h04);
    rbr_rd = 1; step();
    fifo_en = 1; ier_rx = 0; rx_tmo = 1; step();
    chk("R7 tmo masked", iir, 8'hC1);
    ier_rx = 1; #1;
    chk("R13 tmo shown", iir, 8'hCC);
    rbr_rd = 1; step();
    fifo_en = 0; step();
  endtask

  task automatic t_tx();
    thr_empty = 1; step();
    chk("R8 set", iir, 8'h02);
    iir_rd = 1; step();
    chk("R8 iir read clear", iir, 8'h01);
    thr_empty = 1; step();
    thr_wr = 1; step();
    chk("R8 write clear", iir, 8'h01);
    thr_empty = 1; ls_err = 1; step();
    chk("R10 ls over tx", iir, 8'h06);
    iir_rd = 1; step();
    lsr_rd = 1; step();
    chk("R8 survives read", iir, 8'h02);
    iir_rd = 1; step();
    chk("R8 final", iir, 8'h01);
  endtask

  task automatic t_modem();
    modem_chg = 1; step();
    chk("R9 set", iir, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h01);
    out2 = 0; #1;
    chk("R11 out2 gate", {7'd0, irq}, 8'h00);
    chk("R11 iir kept", iir, 8'h00);
    out2 = 1;
    msr_rd = 1; step();
    chk("R9 clear", iir, 8'h01);
  endtask

  task automatic t_priority();
    ls_err = 1; rx_char = 1; thr_empty = 1; modem_chg = 1; step();
    chk("R10 line", iir, 8'h06);
    lsr_rd = 1; step();
    chk("R10 rx", iir, 8'h04);
    rbr_rd = 1; step();
    chk("R10 tx", iir, 8'h02);
    thr_wr = 1; step();
    chk("R10 modem", iir, 8'h00);
    msr_rd = 1; step();
    chk("R10 none", iir, 8'h01);
  endtask

  task automatic t_set_wins();
    ls_err = 1; lsr_rd = 1; step();
    chk("R12 line", iir, 8'h06);
    lsr_rd = 1; step();
    modem_chg = 1; msr_rd = 1; step();
    chk("R12 modem", iir, 8'h00);
    msr_rd = 1; step();
    chk("R12 end", iir, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_fifo_bits();
    t_line();
    t_rx_nofifo();
    t_rx_fifo();
    t_timeout();
    t_enable();
    t_tx();
    t_modem();
    t_priority();
    t_set_wins();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule